// File: doc/BRIEF.md
# Six-Channel Aligned Pulse-Width Modulator

This block turns per-channel period and duty settings into six pulse-width modulated pins. Each channel runs its own counter, which advances only on a single-cycle clock-enable strobe. The strobe comes from one of four prescaled sources produced outside the block. A channel can count in edge-aligned form, where it runs upward and wraps. It can also count in centre-aligned form, where it runs up and then back down. Period and duty are written through a simple register write port into staging registers. The running copy of these values is refreshed only at the end of a period, while the channel is switched off, or when software clears the counter. As a result, waveforms never show a torn period.

Adjacent channels (0/1, 2/3, 4/5) can be merged into one 16-bit channel. In that mode the odd channel's settings and pin drive the merged channel, and the even pin rests low. A freeze input stops every counter without losing its state. An emergency shutdown input overrides all pins with a selectable safe level.

Top module: `pwm_six_ch`

## Requirements
- R1: After reset every staging value, working value and counter is zero, so a disabled channel's pin shows its inactive level (the inverse of its polarity bit).
- R2: In edge-aligned mode (`center_i` bit 0) an enabled channel's counter steps 0,1,…,P−1 on successive strobes and then wraps to 0. The active level is driven while the count is below the duty value D.
- R3: In centre-aligned mode (`center_i` bit 1) the counter steps up 0…P−1, repeats P−1, and steps down to 0, giving 2·P strobes per period. The active level is driven while the count is below D, for 2·D strobes per period.
- R4: Polarity bit 1 makes the active level high; polarity bit 0 makes it low.
- R5: D = 0 keeps the pin at the inactive level for the whole period. D ≥ P with D ≠ 0 keeps the pin at the active level.
- R6: Writes of period or duty reach only the staging registers. The working values take the staged ones when the period ends: the wrap to 0 in edge-aligned mode, or the step after the descending count reaches 0 in centre-aligned mode.
- R7: While a channel's enable bit is 0, its counter is held at 0, its pin shows the inactive level, and its working values follow the staging registers every cycle.
- R8: A write with `wr_sel_i` = 2 clears the addressed channel's counter to 0 and loads its staged values at that same clock edge.
- R9: Strobe bits are assigned A=0, SA=1, B=2, SB=3. Channels 0, 1, 4 and 5 use A (`csel_i` bit 0) or SA (bit 1); channels 2 and 3 use B or SB.
- R10: While `freeze_i` is high, no counter advances. Writes, clears and enable changes still act.
- R11: When `concat_i[k]` is 1, channels 2k and 2k+1 form one 16-bit channel. Its period and duty are {staged value of 2k, staged value of 2k+1}, with channel 2k as the upper byte. Enable, polarity, alignment and clock select are taken from channel 2k+1, and the waveform appears on pin 2k+1. Pin 2k stays low, and a clear addressed to either channel restarts the pair.
- R12: While `shut_i` is high, every pin equals `sd_lvl_i` in the same cycle. Counting continues underneath.
- R13: `wr_sel_i` codes: 0 = period, 1 = duty, 2 = counter clear, 3 = no effect. A write with code 3 alters no staging value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_i | input | 4 | Clock-enable strobes: bit0 A, bit1 SA, bit2 B, bit3 SB |
| freeze_i | input | 1 | Holds every counter while high |
| ch_en_i | input | 6 | Per-channel enable |
| pol_i | input | 6 | Per-channel polarity (1 = active high) |
| center_i | input | 6 | Per-channel alignment (1 = centre-aligned) |
| csel_i | input | 6 | Per-channel source pick (0 = unscaled, 1 = scaled) |
| concat_i | input | 3 | Per-pair 16-bit merge enable |
| shut_i | input | 1 | Emergency shutdown |
| sd_lvl_i | input | 1 | Pin level during shutdown |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 2 | Write target code |
| wr_ch_i | input | 3 | Addressed channel |
| wr_data_i | input | 8 | Write data |
| pwm_o | output | 6 | PWM pins |

## Verification
Each pin is a combinational function of registered counter state and of the enable, polarity, merge and shutdown inputs. A change to those inputs therefore shows on the pins within the same cycle. A strobe or a write sampled at a rising edge changes the pins directly after that edge. The bench drives inputs 1 ns after a rising edge, advances its phase-index model at the rising edge from the values it drove, and compares all six pins at the falling edge. Every comparison therefore sees both the register update of the last edge and the current combinational inputs, with no dependence on process order.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    localparam int PWM_NCH = 6;
    localparam int PWM_CW  = 8;

    typedef enum logic [1:0] {
        WR_PERIOD = 2'd0,
        WR_DUTY   = 2'd1,
        WR_CLEAR  = 2'd2,
        WR_NOP    = 2'd3
    } wr_kind_e;
endpackage

// File: rtl/pwm_shadow_bank.sv
module pwm_shadow_bank
    import pwm_pkg::*;
#(
    parameter int NCH = PWM_NCH,
    parameter int CW  = PWM_CW,
    localparam int IDW = $clog2(NCH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en_i,
    input  logic [1:0]               wr_sel_i,
    input  logic [IDW-1:0]           wr_ch_i,
    input  logic [CW-1:0]            wr_data_i,
    output logic [NCH-1:0][CW-1:0]   per_buf_o,
    output logic [NCH-1:0][CW-1:0]   duty_buf_o,
    output logic [NCH-1:0]           clr_o
);
    typedef struct packed {
        logic [NCH-1:0][CW-1:0] per;
        logic [NCH-1:0][CW-1:0] duty;
    } bank_t;

    bank_t bank_d, bank_q;
    logic  hit;

    // staging registers only; working copies live in the engines
    always_comb begin
        bank_d = bank_q;
        hit    = wr_en_i && (int'(wr_ch_i) < NCH);
        if (hit) begin
            case (wr_sel_i)
                WR_PERIOD: bank_d.per[wr_ch_i]  = wr_data_i;
                WR_DUTY:   bank_d.duty[wr_ch_i] = wr_data_i;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign per_buf_o  = bank_q.per;
    assign duty_buf_o = bank_q.duty;

    for (genvar c = 0; c < NCH; c++) begin : g_clr
        assign clr_o[c] = wr_en_i && (wr_sel_i == 2'(WR_CLEAR)) && (wr_ch_i == IDW'(c));
    end
endmodule

// File: rtl/pwm_tick_route.sv
module pwm_tick_route #(
    parameter int             NCH          = 6,
    parameter logic [NCH-1:0] GROUP_B_MASK = 6'b001100,
    localparam int            NPAIR        = NCH / 2
) (
    input  logic [3:0]       strobe_i,
    input  logic             freeze_i,
    input  logic [NCH-1:0]   csel_i,
    input  logic [NPAIR-1:0] concat_i,
    output logic [NCH-1:0]   tick_o
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam int   HI = c | 1;
        localparam logic GB = GROUP_B_MASK[c];
        logic scaled;
        // a merged pair takes its source pick from the odd member
        assign scaled    = concat_i[c/2] ? csel_i[HI] : csel_i[c];
        assign tick_o[c] = !freeze_i && strobe_i[{GB, scaled}];
    end
endmodule

// File: rtl/pwm_chan_engine.sv
module pwm_chan_engine #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         en_i,
    input  logic         center_i,
    input  logic         pol_i,
    input  logic         clr_i,
    input  logic [W-1:0] per_buf_i,
    input  logic [W-1:0] duty_buf_i,
    output logic         pin_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         down;
        logic [W-1:0] per;
        logic [W-1:0] duty;
    } eng_t;

    eng_t       eng_d, eng_q;
    logic [W:0] cnt_inc;
    logic       reach_top;
    logic       load;
    logic       active;

    assign cnt_inc   = {1'b0, eng_q.cnt} + (W+1)'(1);
    assign reach_top = cnt_inc >= {1'b0, eng_q.per};

    always_comb begin
        eng_d = eng_q;
        load  = 1'b0;
        if (!en_i || clr_i) begin
            eng_d.cnt  = '0;
            eng_d.down = 1'b0;
            load       = 1'b1;
        end else if (tick_i) begin
            if (!center_i) begin
                eng_d.down = 1'b0;
                if (reach_top) begin
                    eng_d.cnt = '0;
                    load      = 1'b1;
                end else begin
                    eng_d.cnt = cnt_inc[W-1:0];
                end
            end else if (!eng_q.down) begin
                if (reach_top) begin
                    eng_d.down = 1'b1;          // top value is held for one more strobe
                end else begin
                    eng_d.cnt = cnt_inc[W-1:0];
                end
            end else begin
                if (eng_q.cnt == '0) begin
                    eng_d.down = 1'b0;
                    load       = 1'b1;
                end else begin
                    eng_d.cnt = eng_q.cnt - W'(1);
                end
            end
        end
        if (load) begin
            eng_d.per  = per_buf_i;
            eng_d.duty = duty_buf_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q <= '0;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign active = (eng_q.duty != '0) &&
                    ((eng_q.duty >= eng_q.per) || (eng_q.cnt < eng_q.duty));
    assign pin_o  = en_i ? (pol_i ? active : !active) : !pol_i;
endmodule

// File: rtl/pwm_six_ch.sv
module pwm_six_ch
    import pwm_pkg::*;
#(
    parameter int             NCH          = PWM_NCH,
    parameter int             CW           = PWM_CW,
    parameter logic [NCH-1:0] GROUP_B_MASK = 6'b001100,
    localparam int            NPAIR        = NCH / 2,
    localparam int            IDW          = $clog2(NCH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       strobe_i,
    input  logic             freeze_i,
    input  logic [NCH-1:0]   ch_en_i,
    input  logic [NCH-1:0]   pol_i,
    input  logic [NCH-1:0]   center_i,
    input  logic [NCH-1:0]   csel_i,
    input  logic [NPAIR-1:0] concat_i,
    input  logic             shut_i,
    input  logic             sd_lvl_i,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_sel_i,
    input  logic [IDW-1:0]   wr_ch_i,
    input  logic [CW-1:0]    wr_data_i,
    output logic [NCH-1:0]   pwm_o
);
    logic [NCH-1:0][CW-1:0] per_buf;
    logic [NCH-1:0][CW-1:0] duty_buf;
    logic [NCH-1:0]         clr;
    logic [NCH-1:0]         tick;
    logic [NCH-1:0]         raw_pin;

    pwm_shadow_bank #(.NCH(NCH), .CW(CW)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en_i),
        .wr_sel_i   (wr_sel_i),
        .wr_ch_i    (wr_ch_i),
        .wr_data_i  (wr_data_i),
        .per_buf_o  (per_buf),
        .duty_buf_o (duty_buf),
        .clr_o      (clr)
    );

    pwm_tick_route #(.NCH(NCH), .GROUP_B_MASK(GROUP_B_MASK)) u_route (
        .strobe_i (strobe_i),
        .freeze_i (freeze_i),
        .csel_i   (csel_i),
        .concat_i (concat_i),
        .tick_o   (tick)
    );

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        localparam int LO = 2 * p;
        localparam int HI = 2 * p + 1;

        logic [2*CW-1:0] hi_per;
        logic [2*CW-1:0] hi_duty;
        logic            hi_clr;

        // merged pair: even channel supplies the upper byte
        assign hi_per  = concat_i[p] ? {per_buf[LO],  per_buf[HI]}  : {CW'(0), per_buf[HI]};
        assign hi_duty = concat_i[p] ? {duty_buf[LO], duty_buf[HI]} : {CW'(0), duty_buf[HI]};
        assign hi_clr  = clr[HI] || (concat_i[p] && clr[LO]);

        pwm_chan_engine #(.W(CW)) u_lo (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick_i     (tick[LO]),
            .en_i       (ch_en_i[LO] && !concat_i[p]),
            .center_i   (center_i[LO]),
            .pol_i      (pol_i[LO]),
            .clr_i      (clr[LO]),
            .per_buf_i  (per_buf[LO]),
            .duty_buf_i (duty_buf[LO]),
            .pin_o      (raw_pin[LO])
        );

        pwm_chan_engine #(.W(2*CW)) u_hi (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick_i     (tick[HI]),
            .en_i       (ch_en_i[HI]),
            .center_i   (center_i[HI]),
            .pol_i      (pol_i[HI]),
            .clr_i      (hi_clr),
            .per_buf_i  (hi_per),
            .duty_buf_i (hi_duty),
            .pin_o      (raw_pin[HI])
        );
    end

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            if (shut_i) begin
                pwm_o[c] = sd_lvl_i;
            end else if (((c % 2) == 0) && concat_i[c/2]) begin
                pwm_o[c] = 1'b0;
            end else begin
                pwm_o[c] = raw_pin[c];
            end
        end
    end
endmodule

// File: rtl/pwm_six_ch_chk.sv
module pwm_six_ch_chk #(
    parameter int  NCH   = 6,
    localparam int NPAIR = NCH / 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             freeze_i,
    input logic [NCH-1:0]   ch_en_i,
    input logic [NCH-1:0]   pol_i,
    input logic [NPAIR-1:0] concat_i,
    input logic             shut_i,
    input logic             sd_lvl_i,
    input logic             wr_en_i,
    input logic [NCH-1:0]   pwm_o
);
    p_shut_level_r12: assert property (@(posedge clk) disable iff (!rst_n)
        shut_i |-> (pwm_o == {NCH{sd_lvl_i}}));

    // R10: a frozen cycle with no write and steady controls leaves every pin unchanged
    p_freeze_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(freeze_i) && !$past(wr_en_i) &&
         $stable(ch_en_i) && $stable(pol_i) && $stable(concat_i) &&
         $stable(shut_i) && $stable(sd_lvl_i)) |-> $stable(pwm_o));

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam bit EVEN = (c % 2) == 0;

        p_off_inactive_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (!shut_i && !ch_en_i[c] && !(EVEN && concat_i[c/2])) |-> (pwm_o[c] == !pol_i[c]));

        if (EVEN) begin : g_even
            p_even_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
                (!shut_i && concat_i[c/2]) |-> !pwm_o[c]);
        end
    end
endmodule

bind pwm_six_ch pwm_six_ch_chk #(.NCH(NCH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .freeze_i (freeze_i),
    .ch_en_i  (ch_en_i),
    .pol_i    (pol_i),
    .concat_i (concat_i),
    .shut_i   (shut_i),
    .sd_lvl_i (sd_lvl_i),
    .wr_en_i  (wr_en_i),
    .pwm_o    (pwm_o)
);

// File: tb/tb_pwm_six_ch.sv
`timescale 1ns/1ps
module tb_pwm_six_ch;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] strobe_i = '0;
    logic       freeze_i = 1'b0;
    logic [5:0] ch_en_i = '0;
    logic [5:0] pol_i = '1;
    logic [5:0] center_i = '0;
    logic [5:0] csel_i = '0;
    logic [2:0] concat_i = '0;
    logic       shut_i = 1'b0;
    logic       sd_lvl_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [1:0] wr_sel_i = '0;
    logic [2:0] wr_ch_i = '0;
    logic [7:0] wr_data_i = '0;
    logic [5:0] pwm_o;

    always #2.5 clk = ~clk;

    pwm_six_ch dut (
        .clk(clk), .rst_n(rst_n), .strobe_i(strobe_i), .freeze_i(freeze_i),
        .ch_en_i(ch_en_i), .pol_i(pol_i), .center_i(center_i), .csel_i(csel_i),
        .concat_i(concat_i), .shut_i(shut_i), .sd_lvl_i(sd_lvl_i),
        .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_ch_i(wr_ch_i),
        .wr_data_i(wr_data_i), .pwm_o(pwm_o)
    );

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    chk_on  = 0;
    bit    done    = 0;
    bit    rnd_strobe = 0;
    logic [3:0]  fix_strobe = 4'hF;
    logic [15:0] lfsr = 16'hACE1;
    string cur_req = "R1";

    // behavioural model: phase index inside the current period
    int m_ph[6];
    int m_wp[6];
    int m_wd[6];
    int b_per[6];
    int b_duty[6];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 6; c++) begin
                m_ph[c] = 0; m_wp[c] = 0; m_wd[c] = 0; b_per[c] = 0; b_duty[c] = 0;
            end
        end else begin
            for (int c = 0; c < 6; c++) begin
                bit merged, odd, een, tk, clr;
                int ctl, grp, idx, bp, bd, len;
                odd    = (c % 2) == 1;
                merged = concat_i[c/2];
                een    = ch_en_i[c] && (odd || !merged);
                ctl    = merged ? (c | 1) : c;
                grp    = (c == 2 || c == 3) ? 1 : 0;
                idx    = grp * 2 + int'(csel_i[ctl]);
                tk     = !freeze_i && strobe_i[idx];
                clr    = wr_en_i && wr_sel_i == 2'd2 &&
                         (int'(wr_ch_i) == c || (odd && merged && int'(wr_ch_i) == c - 1));
                bp     = (odd && merged) ? b_per[c-1] * 256 + b_per[c]   : b_per[c];
                bd     = (odd && merged) ? b_duty[c-1] * 256 + b_duty[c] : b_duty[c];
                if (center_i[c]) len = (m_wp[c] == 0) ? 2 : 2 * m_wp[c];
                else             len = (m_wp[c] == 0) ? 1 : m_wp[c];
                if (!een || clr) begin
                    m_ph[c] = 0; m_wp[c] = bp; m_wd[c] = bd;
                end else if (tk) begin
                    m_ph[c] = m_ph[c] + 1;
                    if (m_ph[c] >= len) begin
                        m_ph[c] = 0; m_wp[c] = bp; m_wd[c] = bd;
                    end
                end
            end
            if (wr_en_i && wr_ch_i < 3'd6) begin
                if (wr_sel_i == 2'd0) b_per[wr_ch_i]  = int'(wr_data_i);
                if (wr_sel_i == 2'd1) b_duty[wr_ch_i] = int'(wr_data_i);
            end
        end
    end

    function automatic logic [5:0] model_pins();
        logic [5:0] e;
        for (int c = 0; c < 6; c++) begin
            int  v;
            bit  act;
            if (shut_i) e[c] = sd_lvl_i;
            else if ((c % 2) == 0 && concat_i[c/2]) e[c] = 1'b0;
            else if (!ch_en_i[c]) e[c] = !pol_i[c];
            else begin
                v = (center_i[c] && m_ph[c] >= m_wp[c]) ? 2 * m_wp[c] - 1 - m_ph[c] : m_ph[c];
                act = (m_wd[c] != 0) && (m_wd[c] >= m_wp[c] || v < m_wd[c]);
                e[c] = pol_i[c] ? act : !act;
            end
        end
        return e;
    endfunction

    always @(negedge clk) begin
        if (rst_n && chk_on && !done) begin
            logic [5:0] exp_v;
            exp_v = model_pins();
            n_tests++;
            if (pwm_o !== exp_v) begin
                n_fail++;
                $display("FAIL %s pins actual=%b expected=%b at %0t", cur_req, pwm_o, exp_v, $time);
            end
        end
    end

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
            wr_en_i = 1'b0;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            strobe_i = rnd_strobe ? lfsr[3:0] : fix_strobe;
        end
    endtask

    task automatic wr(logic [1:0] sel, int ch, int data);
        wr_en_i   = 1'b1;
        wr_sel_i  = sel;
        wr_ch_i   = 3'(ch);
        wr_data_i = 8'(data);
        step(1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog expired (all requirements) actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        pol_i = 6'b101010;
        chk_on = 1;
        cur_req = "R1";
        step(5);

        // R13: program all staging values; code 3 is a no-op
        cur_req = "R13";
        pol_i = 6'b111111;
        for (int c = 0; c < 6; c++) begin
            wr(2'd0, c, 5 + c);
            wr(2'd1, c, 2 + c);
        end
        wr(2'd3, 0, 8'hFF);
        wr(2'd3, 1, 8'h00);

        cur_req = "R2";
        fix_strobe = 4'hF;
        ch_en_i = 6'b111111;
        step(60);

        cur_req = "R4";
        pol_i = 6'b010101;
        step(30);

        cur_req = "R3";
        ch_en_i = '0;
        step(1);
        center_i = 6'b111111;
        ch_en_i = 6'b111111;
        step(80);

        cur_req = "R5";
        wr(2'd1, 0, 0);
        wr(2'd1, 1, 200);
        wr(2'd1, 2, 7);
        step(40);

        cur_req = "R6";
        wr(2'd0, 3, 3);
        step(3);
        wr(2'd1, 3, 1);
        step(40);

        cur_req = "R8";
        step(2);
        wr(2'd2, 4, 0);
        step(5);
        wr(2'd2, 5, 0);
        step(20);

        cur_req = "R9";
        rnd_strobe = 1;
        center_i = 6'b010010;
        csel_i = 6'b100110;
        step(300);
        csel_i = 6'b011001;
        step(200);

        cur_req = "R10";
        freeze_i = 1'b1;
        step(20);
        wr(2'd0, 0, 9);
        step(5);
        freeze_i = 1'b0;
        step(40);

        cur_req = "R7";
        ch_en_i[5] = 1'b0;
        wr(2'd0, 5, 4);
        wr(2'd1, 5, 3);
        step(10);
        ch_en_i[5] = 1'b1;
        step(40);

        cur_req = "R12";
        shut_i = 1'b1; sd_lvl_i = 1'b1;
        step(10);
        sd_lvl_i = 1'b0;
        step(10);
        shut_i = 1'b0;
        step(20);

        cur_req = "R11";
        rnd_strobe = 0;
        fix_strobe = 4'hF;
        ch_en_i = '0;
        csel_i = '0;
        center_i = 6'b001000;
        pol_i = 6'b111111;
        wr(2'd0, 0, 1);   wr(2'd0, 1, 2);
        wr(2'd1, 0, 0);   wr(2'd1, 1, 8'h81);
        wr(2'd0, 2, 0);   wr(2'd0, 3, 16);
        wr(2'd1, 2, 0);   wr(2'd1, 3, 5);
        wr(2'd0, 4, 1);   wr(2'd0, 5, 0);
        wr(2'd1, 4, 0);   wr(2'd1, 5, 8'hFF);
        concat_i = 3'b111;
        ch_en_i = 6'b111111;
        step(600);
        wr(2'd2, 0, 0);
        step(700);
        concat_i = 3'b010;
        step(100);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule